// File: doc/BRIEF.md
# Four-Pin Multi-Function GPIO Controller

This block controls a small set of general-purpose pins that share their pads with a serial audio port. Each pin has a byte-wide configuration register. A 4-bit function code in that register gives the pin one of these behaviours:

- a plain input;
- an input filtered by a debounce counter, with seven selectable hold times;
- an input that software reads through the register interface;
- an output driven by a software-written bit or by a signal from the processing core, each with or without the pad pull-up;
- an output that reports one of two sticky error flags.

A global enable hands the pads to the GPIO logic. While it is low, the pads are left to the serial port.

Software reaches the block through a simple synchronous register port. The port has two banks of per-pin registers. The configuration bank holds the function codes. The data bank returns the conditioned input level and holds the software output bit. The processing core reads the conditioned input levels and supplies its own output levels. Two event inputs set the error flags. Debounce hold times are converted to clock ticks from a parameterized clock frequency in kHz.

Top module: `gpio_func_ctrl`

## Requirements
- R1: After reset every function code is 0000, every data latch is 0, `pad_oe`, `pad_out`, `pad_pu` and `core_in` are all 0, and every register reads 0.
- R2: The configuration register of pin i sits at address i (0..3). A write stores `reg_wdata[3:0]` and reads return it in bits [3:0]. Bits [7:4] read as zero and writes to them are ignored.
- R3: While `gpio_en` is 0, every pin has `pad_oe`=0, `pad_pu`=0, `pad_out`=0 and `core_in`=0, whatever its code.
- R4: With code 0000, `core_in[i]` follows `pad_in[i]` through a two-flop synchronizer. The change appears two rising edges after the pad changes.
- R5: Codes 0001..0111 select debounce times of 0.3, 0.6, 0.9, 5, 10, 20 and 40 ms, giving L = CLK_KHZ*{3,6,9,50,100,200,400}/10 ticks. The filtered level changes 2+L edges after the pad settles at a new level. A pulse that lasts at most L-1 cycles is rejected.
- R6: With code 1000, `core_in[i]` is 0 and the synchronized pad level is readable at bit 0 of the data register.
- R7: Codes 1001 and 1010 set `pad_oe`=1 and drive `pad_out` from the software output bit. `pad_pu` is 1 for 1001 and 0 for 1010.
- R8: Codes 1011 and 1100 set `pad_oe`=1 and drive `pad_out` from `core_out[i]`. `pad_pu` is 1 for 1011 and 0 for 1100.
- R9: Code 1110 drives the CRC error flag and code 1111 drives the watchdog error flag, both with `pad_oe`=1. A flag is set one cycle after its event input is high, whether or not any pin selects it. It stays set until reset.
- R10: Code 1101 is reserved: `pad_oe`=0, `pad_pu`=0 and `pad_out`=0. Whenever `pad_oe` is 0, `pad_out` is 0.
- R11: The data register of pin i sits at address 4+i. On a read, bit 0 is the conditioned input level for codes 0000..1000 (0 for all other codes) and bit 1 is the software output bit. A write stores `reg_wdata[1]` as that bit. All other bits read zero and are ignored on write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_en | input | 1 | Hands the shared pads to GPIO use |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (bank in the top bit, pin index below) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pad_in | input | 4 | Sampled pad levels |
| pad_oe | output | 4 | Pad output enables |
| pad_out | output | 4 | Pad output levels |
| pad_pu | output | 4 | Pad pull-up enables |
| core_out | input | 4 | Output levels from the processing core |
| core_in | output | 4 | Conditioned input levels to the processing core |
| crc_err_evt | input | 1 | CRC error event |
| wdog_err_evt | input | 1 | Watchdog error event |

## Verification
A corrupted function code or a lost data latch shows up at the pad controls and in the register readback one cycle after the write. A debounce counter that reloads wrongly or compares against the wrong limit moves the `core_in` transition off the edge 2+L after the pad change, so it is caught on that exact edge. It is also caught when a pulse of L-1 cycles leaks through. A sticky flag that drops, or that sets without an event, is visible on any pin coded 1110 or 1111 within one cycle.

// File: rtl/gpio_func_pkg.sv
package gpio_func_pkg;

   typedef enum logic [3:0] {
      FN_IN_RAW      = 4'h0,
      FN_IN_DB1      = 4'h1,
      FN_IN_DB2      = 4'h2,
      FN_IN_DB3      = 4'h3,
      FN_IN_DB4      = 4'h4,
      FN_IN_DB5      = 4'h5,
      FN_IN_DB6      = 4'h6,
      FN_IN_DB7      = 4'h7,
      FN_IN_PORT     = 4'h8,
      FN_OUT_PORT_PU = 4'h9,
      FN_OUT_PORT    = 4'hA,
      FN_OUT_CORE_PU = 4'hB,
      FN_OUT_CORE    = 4'hC,
      FN_RSVD        = 4'hD,
      FN_OUT_CRC     = 4'hE,
      FN_OUT_WDOG    = 4'hF
   } pin_fn_e;

   typedef struct packed {
      logic oe;
      logic drv;
      logic pu;
   } pad_ctl_t;

   // hold time in tenths of a millisecond for a debounce selector
   function automatic int unsigned db_tenths(input logic [2:0] sel);
      case (sel)
         3'd1:    return 3;
         3'd2:    return 6;
         3'd3:    return 9;
         3'd4:    return 50;
         3'd5:    return 100;
         3'd6:    return 200;
         3'd7:    return 400;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/gpio_debounce.sv
module gpio_debounce
   import gpio_func_pkg::*;
#(
   parameter int unsigned CLK_KHZ     = 12288,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       raw_in,
   input  logic [2:0] sel,     // 0 = bypass
   output logic       level
);
   localparam int unsigned MAX_TICKS = CLK_KHZ * 40;
   localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

   initial begin
      assert (CLK_KHZ >= 10) else $error("CLK_KHZ too small for 0.3 ms");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be >= 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic                   stable_q;
   logic [CNT_W-1:0]       cnt_q;
   logic [CNT_W-1:0]       limit;
   logic                   bypass;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= raw_in;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
         end
      end
   endgenerate

   assign synced = sync_q[SYNC_STAGES-1];
   assign bypass = (sel == 3'd0);

   always_comb limit = CNT_W'(CLK_KHZ * db_tenths(sel) / 10);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stable_q <= 1'b0;
         cnt_q    <= '0;
      end else if (bypass) begin
         stable_q <= synced;
         cnt_q    <= '0;
      end else if (synced == stable_q) begin
         cnt_q    <= '0;
      end else if (cnt_q >= limit - CNT_W'(1)) begin
         stable_q <= synced;
         cnt_q    <= '0;
      end else begin
         cnt_q    <= cnt_q + CNT_W'(1);
      end
   end

   assign level = bypass ? synced : stable_q;

   // R5: the filtered level holds while the input agrees with it
   p_db_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && synced == stable_q) |=> (stable_q == $past(stable_q)));

   // R5: the filtered level moves only on a counter expiry
   p_db_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && cnt_q < limit - CNT_W'(1)) |=> $stable(stable_q));

endmodule

// File: rtl/gpio_err_sticky.sv
module gpio_err_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic crc_evt,
   input  logic wdog_evt,
   output logic crc_flag,
   output logic wdog_flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_flag  <= 1'b0;
         wdog_flag <= 1'b0;
      end else begin
         if (crc_evt)  crc_flag  <= 1'b1;
         if (wdog_evt) wdog_flag <= 1'b1;
      end
   end

   // R9: once set, a flag never clears before reset
   p_crc_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      crc_flag |=> crc_flag);
   p_wdog_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_flag |=> wdog_flag);
   // R9: a flag rises only after an event
   p_crc_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_flag) |-> $past(crc_evt));

endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
   import gpio_func_pkg::*;
(
   input  logic       en,
   input  logic [3:0] code,
   input  logic       port_bit,
   input  logic       core_bit,
   input  logic       crc_flag,
   input  logic       wdog_flag,
   input  logic       cond_in,
   output pad_ctl_t   pad,
   output logic       to_core,
   output logic       to_port
);
   pin_fn_e fn;
   assign fn = pin_fn_e'(code);

   always_comb begin
      pad     = '0;
      to_core = 1'b0;
      to_port = 1'b0;
      if (en) begin
         case (fn)
            FN_IN_PORT:     to_port = cond_in;
            FN_OUT_PORT_PU: pad = '{oe: 1'b1, drv: port_bit,  pu: 1'b1};
            FN_OUT_PORT:    pad = '{oe: 1'b1, drv: port_bit,  pu: 1'b0};
            FN_OUT_CORE_PU: pad = '{oe: 1'b1, drv: core_bit,  pu: 1'b1};
            FN_OUT_CORE:    pad = '{oe: 1'b1, drv: core_bit,  pu: 1'b0};
            FN_OUT_CRC:     pad = '{oe: 1'b1, drv: crc_flag,  pu: 1'b0};
            FN_OUT_WDOG:    pad = '{oe: 1'b1, drv: wdog_flag, pu: 1'b0};
            FN_RSVD:        pad = '0;
            default: begin
               to_core = cond_in;
               to_port = cond_in;
            end
         endcase
      end
   end

endmodule

// File: rtl/gpio_func_ctrl.sv
module gpio_func_ctrl
   import gpio_func_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CLK_KHZ     = 12288,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned IDX_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
   localparam int unsigned ADDR_W     = IDX_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                gpio_en,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_pu,
   input  logic [NUM_PINS-1:0] core_out,
   output logic [NUM_PINS-1:0] core_in,
   input  logic                crc_err_evt,
   input  logic                wdog_err_evt
);
   localparam int unsigned CODE_W = 4;

   initial begin
      assert (NUM_PINS >= 1 && (1 << IDX_W) == NUM_PINS)
         else $error("NUM_PINS must be a power of two");
      assert (DATA_W >= CODE_W) else $error("DATA_W must hold a function code");
   end

   logic [CODE_W-1:0]   cfg_q  [NUM_PINS];
   logic [NUM_PINS-1:0] dout_q;
   logic [NUM_PINS-1:0] cond_lvl;
   logic [NUM_PINS-1:0] port_lvl;
   logic                crc_flag;
   logic                wdog_flag;
   logic                bank_data;
   logic [IDX_W-1:0]    idx;
   logic                unused_wdata;

   assign bank_data    = reg_addr[ADDR_W-1];
   assign idx          = reg_addr[IDX_W-1:0];
   assign unused_wdata = ^reg_wdata;

   gpio_err_sticky u_sticky (
      .clk       (clk),
      .rst_n     (rst_n),
      .crc_evt   (crc_err_evt),
      .wdog_evt  (wdog_err_evt),
      .crc_flag  (crc_flag),
      .wdog_flag (wdog_flag)
   );

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         logic [2:0] db_sel;
         pad_ctl_t   pad;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cfg_q[p]  <= '0;
               dout_q[p] <= 1'b0;
            end else if (reg_wr && idx == IDX_W'(p)) begin
               if (bank_data) dout_q[p] <= reg_wdata[1];
               else           cfg_q[p]  <= reg_wdata[CODE_W-1:0];
            end
         end

         // debounce only for input codes 1..7
         assign db_sel = cfg_q[p][3] ? 3'd0 : cfg_q[p][2:0];

         gpio_debounce #(
            .CLK_KHZ     (CLK_KHZ),
            .SYNC_STAGES (SYNC_STAGES)
         ) u_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_in (pad_in[p]),
            .sel    (db_sel),
            .level  (cond_lvl[p])
         );

         gpio_pin_ctl u_ctl (
            .en        (gpio_en),
            .code      (cfg_q[p]),
            .port_bit  (dout_q[p]),
            .core_bit  (core_out[p]),
            .crc_flag  (crc_flag),
            .wdog_flag (wdog_flag),
            .cond_in   (cond_lvl[p]),
            .pad       (pad),
            .to_core   (core_in[p]),
            .to_port   (port_lvl[p])
         );

         assign pad_oe[p]  = pad.oe;
         assign pad_out[p] = pad.drv;
         assign pad_pu[p]  = pad.pu;

         // R7: port-driven output codes follow the latch written one cycle before
         p_port_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (gpio_en && (cfg_q[p] == 4'h9 || cfg_q[p] == 4'hA))
               |-> (pad_oe[p] && pad_out[p] == dout_q[p]));
         // R10: the reserved code never drives or pulls the pad
         p_rsvd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[p] == 4'hD) |-> (!pad_oe[p] && !pad_pu[p] && !pad_out[p]));
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      if (bank_data) begin
         reg_rdata[0] = port_lvl[idx];
         reg_rdata[1] = dout_q[idx];
      end else begin
         reg_rdata[CODE_W-1:0] = cfg_q[idx];
      end
   end

   // R3: a disabled block leaves every pad to the serial port
   p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !gpio_en |-> (pad_oe == '0 && pad_pu == '0 && core_in == '0));
   // R2: reserved upper bits always read back as zero
   p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1:CODE_W] == '0);

endmodule

// File: tb/gpio_func_ctrl_tb.sv
module gpio_func_ctrl_tb;
   localparam int NP  = 4;
   localparam int KHZ = 10;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       gpio_en = 0;
   logic       reg_wr = 0;
   logic [2:0] reg_addr = 0;
   logic [7:0] reg_wdata = 0;
   logic [7:0] reg_rdata;
   logic [3:0] pad_in = 0, pad_oe, pad_out, pad_pu, core_out = 0, core_in;
   logic       crc_err_evt = 0, wdog_err_evt = 0;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   gpio_func_ctrl #(.CLK_KHZ(KHZ)) u_dut (
      .clk(clk), .rst_n(rst_n), .gpio_en(gpio_en), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
      .core_out(core_out), .core_in(core_in),
      .crc_err_evt(crc_err_evt), .wdog_err_evt(wdog_err_evt));

   // model state
   logic [3:0] m_code [NP];
   logic [3:0] m_lat;
   logic       m_crc, m_wdog;

   function automatic int ticks(input int code);
      int t[8] = '{0, 3, 6, 9, 50, 100, 200, 400};
      return KHZ * t[code] / 10;
   endfunction

   function automatic logic [2:0] exp_pad(input logic en, input logic [3:0] c,
                                          input logic lat, input logic co);
      // {oe, out, pu}
      if (!en) return 3'b000;
      case (c)
         4'h9: return {1'b1, lat, 1'b1};
         4'hA: return {1'b1, lat, 1'b0};
         4'hB: return {1'b1, co, 1'b1};
         4'hC: return {1'b1, co, 1'b0};
         4'hE: return {1'b1, m_crc, 1'b0};
         4'hF: return {1'b1, m_wdog, 1'b0};
         default: return 3'b000;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0;
      if (a[2]) m_lat[a[1:0]] = d[1];
      else      m_code[a[1:0]] = d[3:0];
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'h1761));
      for (int i = 0; i < NP; i++) m_code[i] = 0;
      m_lat = 0; m_crc = 0; m_wdog = 0;

      // R1: reset state
      repeat (3) @(negedge clk);
      rst_n = 1;
      gpio_en = 1;
      #1;
      check("R1 pad_oe", pad_oe, 0);
      check("R1 pad_pu", pad_pu, 0);
      check("R1 pad_out", pad_out, 0);
      check("R1 core_in", core_in, 0);
      for (int a = 0; a < 8; a++) begin
         rd(a[2:0], d);
         check("R1 read", d, 0);
      end

      // R2: config write with junk upper bits
      wr(3'd2, 8'hF5);
      rd(3'd2, d);
      check("R2 cfg readback", d, 8'h05);
      wr(3'd2, 8'h00);

      // R11: data latch write, other bits ignored
      wr(3'd5, 8'hFE);
      rd(3'd5, d);
      check("R11 data latch", d, 8'h02);
      wr(3'd5, 8'h00);

      // R4: raw input timing on pin 1
      @(negedge clk); pad_in[1] = 1;
      @(posedge clk); #1 check("R4 one edge", core_in[1], 0);
      @(posedge clk); #1 check("R4 two edges", core_in[1], 1);
      @(negedge clk); pad_in[1] = 0;
      repeat (3) @(posedge clk);

      // R5: debounce timing and glitch rejection for every duration, pin 0
      for (int k = 1; k < 8; k++) begin
         int L;
         L = ticks(k);
         wr(3'd0, 8'(k));
         @(negedge clk); pad_in[0] = 0;
         repeat (L + 6) @(negedge clk);
         pad_in[0] = 1;
         repeat (L - 1) @(negedge clk);
         pad_in[0] = 0;
         repeat (L + 6) @(posedge clk);
         #1 check($sformatf("R5 glitch rejected code %0d", k), core_in[0], 0);
         @(negedge clk); pad_in[0] = 1;
         repeat (L + 1) @(posedge clk);
         #1 check($sformatf("R5 not yet code %0d", k), core_in[0], 0);
         @(posedge clk);
         #1 check($sformatf("R5 settled code %0d", k), core_in[0], 1);
         @(negedge clk); pad_in[0] = 0;
         repeat (L + 4) @(posedge clk);
      end
      wr(3'd0, 8'h00);

      // R6: port-read input
      wr(3'd3, 8'h08);
      @(negedge clk); pad_in[3] = 1;
      repeat (3) @(posedge clk);
      #1 check("R6 core_in masked", core_in[3], 0);
      rd(3'd7, d);
      check("R6 port read", d, 8'h01);

      // R10: reserved code
      wr(3'd3, 8'h0D);
      #1 check("R10 reserved", {pad_oe[3], pad_out[3], pad_pu[3]}, 0);
      rd(3'd7, d);
      check("R11 bit0 zero for reserved", d[0], 0);
      @(negedge clk); pad_in[3] = 0;

      // R9: sticky flags
      wr(3'd0, 8'h0E);
      wr(3'd1, 8'h0F);
      #1 check("R9 crc idle", {pad_oe[0], pad_out[0]}, 2'b10);
      @(negedge clk); crc_err_evt = 1;
      @(negedge clk); crc_err_evt = 0; m_crc = 1;
      check("R9 crc set", pad_out[0], 1);
      check("R9 wdog still clear", pad_out[1], 0);
      repeat (5) @(negedge clk);
      check("R9 crc held", pad_out[0], 1);
      wr(3'd0, 8'h00);
      @(negedge clk); wdog_err_evt = 1;
      @(negedge clk); wdog_err_evt = 0; m_wdog = 1;
      check("R9 wdog set", pad_out[1], 1);

      // R3: disable masks every code
      @(negedge clk); gpio_en = 0;
      #1 check("R3 disabled", {pad_oe, pad_pu, pad_out, core_in}, 0);
      gpio_en = 1;

      // R7 R8 R10 R11 R3: random configurations
      for (int it = 0; it < 80; it++) begin
         logic [3:0] pick [8] = '{4'h0, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE};
         for (int p = 0; p < NP; p++) begin
            logic [3:0] c;
            c = ($urandom % 9 == 8) ? 4'hF : pick[$urandom % 8];
            wr(3'(p), {4'($urandom), c});
            wr(3'(4 + p), 8'($urandom));
         end
         @(negedge clk);
         gpio_en = ($urandom % 4) != 0;
         core_out = 4'($urandom);
         pad_in = 4'($urandom);
         repeat (3) @(posedge clk);
         #1;
         for (int p = 0; p < NP; p++) begin
            logic [2:0] e;
            logic ein;
            e = exp_pad(gpio_en, m_code[p], m_lat[p], core_out[p]);
            check("R7 R8 R10 pad ctl", {pad_oe[p], pad_out[p], pad_pu[p]}, e);
            ein = gpio_en && m_code[p] == 4'h0 && pad_in[p];
            check("R3 R4 core_in", core_in[p], ein);
            rd(3'(4 + p), d);
            check("R11 data read", d,
                  {6'b0, m_lat[p], gpio_en && m_code[p][2:0] == 0 && !(m_code[p][3] && m_code[p] != 4'h8) && pad_in[p]});
         end
      end

      summary();
   end
endmodule